// File: doc/BRIEF.md
# SAR Converter Conversion-Cycle Controller

This block is the host side of a link to a 14-bit multichannel successive-approximation converter. The converter has no busy output, and all reads and writes take place after the conversion has ended. Each request runs one full cycle. The block raises the convert-start line and holds it high for a programmed number of system clocks, which covers the conversion time. It then lowers the line and runs one serial frame with the clock idling low (SPI mode 0). During that frame it shifts the 14-bit configuration word out and the finished result in.

The converter applies each configuration two cycles after it is written. Its first three results after power-up are meaningless. The controller tracks this pipeline itself. It suppresses those three results, and it tags every result it delivers with the channel field of the configuration written two cycles before that result. The result, a one-cycle valid strobe and the channel tag are the outputs that downstream logic consumes.

When the echo input is set, the frame is twice as long so that the converter can return its configuration. The second half of that frame is clocked through and discarded.

Top module: `adc_cycle_ctrl`

## Requirements
- R1: After reset, `cnv`, `sck`, `din` and `res_valid` are all low.
- R2: A `start_req` seen while idle latches `cfg_word`, `echo_en`, `conv_cycles` and `sck_half`. `cnv` is then high for exactly `conv_cycles` system clocks, with a value of 0 treated as 1. `sck` makes no edge while `cnv` is high.
- R3: After `cnv` falls, `sck` starts low and makes 14 rising and 14 falling edges, or 28 of each when `echo_en` was latched high. It then rests low. Each high and each low phase, including the first low phase after `cnv` falls, lasts `sck_half` system clocks, with 0 treated as 1.
- R4: `din` carries the latched configuration word most significant bit first. Bit 13 is present before the first rising `sck` edge, and `din` changes only on falling `sck` edges, so it is stable at every rising edge.
- R5: `sdo` is sampled on the first 14 rising `sck` edges, and the first bit sampled becomes bit 13 of the result. In an echo frame, the bits on rising edges 15 to 28 do not affect `res_data`.
- R6: The frames of the first three cycles after reset produce no `res_valid`. Every later frame ends with `res_valid` high for exactly one clock.
- R7: `res_chan` equals bits [9:7] of the configuration word latched two cycles before the cycle whose result is presented.
- R8: A `start_req` during a cycle is ignored. It produces no extra `cnv` pulse, and it does not replace the word being shifted out.
- R9: `res_data` and `res_chan` change only in a clock where `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request one conversion cycle (taken only when idle) |
| cfg_word | input | 14 | Configuration word to write in this cycle's frame; channel in bits [9:7] |
| echo_en | input | 1 | Double-length frame for configuration echo |
| conv_cycles | input | 16 | Convert-start high time in system clocks |
| sck_half | input | 8 | Serial clock half period in system clocks |
| sdo | input | 1 | Serial data from the converter |
| cnv | output | 1 | Convert-start line to the converter |
| sck | output | 1 | Serial clock, idle low |
| din | output | 1 | Serial configuration data to the converter |
| res_valid | output | 1 | One-clock strobe for a new result |
| res_data | output | 14 | Conversion result |
| res_chan | output | 3 | Channel tag of the result |

## Verification
Several properties are checked on every clock. The serial clock stays quiet while `cnv` is high. `din` holds steady at each rising `sck` edge. Each frame ends on a legal count of falling edges. The valid strobe lasts one clock and never appears before the fourth frame after reset. The outputs hold between strobes, and a start request made during a cycle never causes a new `cnv` pulse. Only the bench's scenarios can show the rest, because each needs a model of the converter: the exact `cnv` width and half-period timing, the configuration bit order, the shifted-in result value, the discarding of echo bits, and the two-cycle channel tag.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  // Cycle sequencing states of the controller.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } cyc_state_e;

endpackage

// File: rtl/adc_sck_div.sv
module adc_sck_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sck,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [DIV_W-1:0] div_q;
  logic             sck_q;
  logic             hit;

  assign hit       = run && (div_q == half - 1'b1);
  assign rise_tick = hit && !sck_q;
  assign fall_tick = hit && sck_q;
  assign sck       = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (hit) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int DW   = 14,
  parameter int EC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DW-1:0]   cfg,
  input  logic [EC_W-1:0] nedges,
  input  logic            rise,
  input  logic            fall,
  input  logic            sdo,
  output logic            din,
  output logic [DW-1:0]   rx,
  output logic            frame_done
);

  localparam logic [EC_W-1:0] DW_E = EC_W'(DW);

  logic [DW-1:0]   tx_q;
  logic [DW-1:0]   rx_q;
  logic            din_q;
  logic [EC_W-1:0] rise_cnt;
  logic [EC_W-1:0] fall_cnt;

  assign frame_done = fall && (fall_cnt == nedges - 1'b1);
  assign din        = din_q;
  assign rx         = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      rx_q     <= '0;
      din_q    <= 1'b0;
      rise_cnt <= '0;
      fall_cnt <= '0;
    end else if (load) begin
      din_q    <= cfg[DW-1];
      tx_q     <= {cfg[DW-2:0], 1'b0};
      rx_q     <= '0;
      rise_cnt <= '0;
      fall_cnt <= '0;
    end else begin
      if (rise && (rise_cnt < DW_E)) begin
        rx_q     <= {rx_q[DW-2:0], sdo};
        rise_cnt <= rise_cnt + 1'b1;
      end
      if (fall) begin
        din_q    <= tx_q[DW-1];
        tx_q     <= {tx_q[DW-2:0], 1'b0};
        fall_cnt <= fall_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_tag_pipe.sv
module adc_tag_pipe #(
  parameter int DW   = 14,
  parameter int CH_W = 3,
  parameter int SKIP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_done,
  input  logic [CH_W-1:0] chan_now,
  input  logic [DW-1:0]   rx,
  output logic            res_valid,
  output logic [DW-1:0]   res_data,
  output logic [CH_W-1:0] res_chan
);

  localparam int              SK_W   = $clog2(SKIP + 1);
  localparam logic [SK_W-1:0] SKIP_V = SK_W'(SKIP);

  logic [CH_W-1:0] ch_d1;
  logic [CH_W-1:0] ch_d2;
  logic [SK_W-1:0] seen;
  logic            primed;

  assign primed = (seen == SKIP_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_d1     <= '0;
      ch_d2     <= '0;
      seen      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else if (frame_done) begin
      res_valid <= primed;
      if (!primed) seen <= seen + 1'b1;
      if (primed) begin
        res_data <= rx;
        res_chan <= ch_d2;
      end
      ch_d2 <= ch_d1;
      ch_d1 <= chan_now;
    end else begin
      res_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_cycle_ctrl.sv
module adc_cycle_ctrl #(
  parameter int DW     = 14,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int CH_W   = 3,
  parameter int CH_LSB = 7,
  parameter int SKIP   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [DW-1:0]    cfg_word,
  input  logic             echo_en,
  input  logic [CNT_W-1:0] conv_cycles,
  input  logic [DIV_W-1:0] sck_half,
  input  logic             sdo,
  output logic             cnv,
  output logic             sck,
  output logic             din,
  output logic             res_valid,
  output logic [DW-1:0]    res_data,
  output logic [CH_W-1:0]  res_chan
);
  import adc_ctrl_pkg::*;

  localparam int EC_W = $clog2(2 * DW + 1);

  function automatic logic [CNT_W-1:0] conv_floor(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

  function automatic logic [DIV_W-1:0] half_floor(input logic [DIV_W-1:0] h);
    return (h == '0) ? DIV_W'(1) : h;
  endfunction

  function automatic logic [EC_W-1:0] edges_for(input logic echo);
    return echo ? EC_W'(2 * DW) : EC_W'(DW);
  endfunction

  function automatic logic [CH_W-1:0] chan_field(input logic [DW-1:0] w);
    return w[CH_LSB +: CH_W];
  endfunction

  cyc_state_e       state;
  logic             cnv_q;
  logic [CNT_W-1:0] conv_cnt;
  logic [DW-1:0]    cfg_q;
  logic             echo_q;
  logic [DIV_W-1:0] half_q;

  // Named internal events, also observed by the bound checker.
  logic cyc_busy;
  logic conv_end;
  logic shift_run;
  logic rise_tick;
  logic fall_tick;
  logic frame_done;
  logic [DW-1:0] rx_word;

  assign cyc_busy  = (state != ST_IDLE);
  assign conv_end  = (state == ST_CONV) && (conv_cnt == CNT_W'(1));
  assign shift_run = (state == ST_SHIFT);
  assign cnv       = cnv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnv_q    <= 1'b0;
      conv_cnt <= '0;
      cfg_q    <= '0;
      echo_q   <= 1'b0;
      half_q   <= DIV_W'(1);
    end else begin
      case (state)
        ST_IDLE: if (start_req) begin
          state    <= ST_CONV;
          cnv_q    <= 1'b1;
          conv_cnt <= conv_floor(conv_cycles);
          cfg_q    <= cfg_word;
          echo_q   <= echo_en;
          half_q   <= half_floor(sck_half);
        end
        ST_CONV: if (conv_end) begin
          state <= ST_SHIFT;
          cnv_q <= 1'b0;
        end else begin
          conv_cnt <= conv_cnt - 1'b1;
        end
        ST_SHIFT: if (frame_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  adc_sck_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (shift_run),
    .half      (half_q),
    .sck       (sck),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  adc_frame_shift #(.DW(DW), .EC_W(EC_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (conv_end),
    .cfg        (cfg_q),
    .nedges     (edges_for(echo_q)),
    .rise       (rise_tick),
    .fall       (fall_tick),
    .sdo        (sdo),
    .din        (din),
    .rx         (rx_word),
    .frame_done (frame_done)
  );

  adc_tag_pipe #(.DW(DW), .CH_W(CH_W), .SKIP(SKIP)) u_tag (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .chan_now   (chan_field(cfg_q)),
    .rx         (rx_word),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_chan   (res_chan)
  );

endmodule

// File: rtl/adc_cycle_ctrl_chk.sv
module adc_cycle_ctrl_chk #(
  parameter int DW   = 14,
  parameter int CH_W = 3,
  parameter int SKIP = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_req,
  input logic            cnv,
  input logic            sck,
  input logic            din,
  input logic            res_valid,
  input logic [DW-1:0]   res_data,
  input logic [CH_W-1:0] res_chan,
  input logic            cyc_busy,
  input logic            frame_done
);

  logic       sck_d;
  logic       cnv_d;
  logic [5:0] falls;
  logic [3:0] frames_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d       <= 1'b0;
      cnv_d       <= 1'b0;
      falls       <= '0;
      frames_seen <= '0;
    end else begin
      sck_d <= sck;
      cnv_d <= cnv;
      if (cnv && !cnv_d) falls <= '0;
      else if (sck_d && !sck) falls <= falls + 1'b1;
      if (frame_done && frames_seen != 4'hF) frames_seen <= frames_seen + 1'b1;
    end
  end

  // R2: the serial clock stays low while convert-start is high
  a_r2_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cnv |-> !sck);

  // R4: configuration data never moves at a rising serial clock edge
  a_r4_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(din));

  // R3: every finished frame had a legal number of falling edges
  a_r3_frame_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv && !cnv_d) |-> (falls == 6'd0 || falls == 6'(DW) || falls == 6'(2 * DW)));

  // R6: the strobe lasts a single clock
  a_r6_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R6: no strobe from the first SKIP frames after reset
  a_r6_skip_startup: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (frames_seen > 4'(SKIP)));

  // R8: a request during a cycle starts nothing
  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && cyc_busy) |=> !$rose(cnv));

  // R9: outputs hold between strobes
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_data) && $stable(res_chan)));

endmodule

bind adc_cycle_ctrl adc_cycle_ctrl_chk #(.DW(DW), .CH_W(CH_W), .SKIP(SKIP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_req  (start_req),
  .cnv        (cnv),
  .sck        (sck),
  .din        (din),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .res_chan   (res_chan),
  .cyc_busy   (cyc_busy),
  .frame_done (frame_done)
);

// File: tb/test_adc_cycle_ctrl.sv
`timescale 1ns/1ps
module test_adc_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic [13:0] cfg_word = '0;
  logic        echo_en = 1'b0;
  logic [15:0] conv_cycles = 16'd1;
  logic [7:0]  sck_half = 8'd1;
  logic        sdo = 1'b0;
  logic        cnv, sck, din, res_valid;
  logic [13:0] res_data;
  logic [2:0]  res_chan;

  always #10 clk = ~clk;

  adc_cycle_ctrl i_adc_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_word(cfg_word),
    .echo_en(echo_en), .conv_cycles(conv_cycles), .sck_half(sck_half),
    .sdo(sdo), .cnv(cnv), .sck(sck), .din(din), .res_valid(res_valid),
    .res_data(res_data), .res_chan(res_chan)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Converter model: result on SDO, samples DIN, measures edges and widths.
  logic [13:0] model_word = '0;
  logic [13:0] adc_sr = '0;
  logic [13:0] din_cap = '0;
  int  din_bits = 0, falls_m = 0, rises_cnv = 0, sck_in_cnv = 0, half_err = 0;
  int  eh = 1;
  time t_rise = 0, t_fall = 0, t_prev = 0;

  always @(posedge cnv) begin
    rises_cnv++;
    t_rise = $time;
    falls_m = 0; din_bits = 0; din_cap = '0; half_err = 0;
  end
  always @(negedge cnv) begin
    t_fall = $time; t_prev = $time;
    adc_sr = model_word; sdo = adc_sr[13];
  end
  always @(negedge sck) begin
    if ($time - t_prev != eh * 20) half_err++;
    t_prev = $time;
    falls_m++;
    adc_sr = {adc_sr[12:0], 1'b1};
    sdo = adc_sr[13];
  end
  always @(posedge sck) begin
    if (cnv) sck_in_cnv++;
    if ($time - t_prev != eh * 20) half_err++;
    t_prev = $time;
    if (din_bits < 14) din_cap = {din_cap[12:0], din};
    din_bits++;
  end

  int vcount = 0;
  logic [13:0] last_data = '0;
  logic [2:0]  last_chan = '0;
  always @(negedge clk) if (res_valid) begin
    vcount++; last_data = res_data; last_chan = res_chan;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  // Bench-side pipeline history
  int cyc_idx = 0;
  logic [13:0] hist1 = '0, hist2 = '0;

  task automatic run_cycle(input logic [13:0] cfg, input logic [13:0] word, input bit echo,
                           input int conv, input int half, input bit intrude);
    int ec, n, r0, v0;
    ec = (conv == 0) ? 1 : conv;
    eh = (half == 0) ? 1 : half;
    n  = echo ? 28 : 14;
    r0 = rises_cnv; v0 = vcount;
    @(negedge clk);
    cfg_word = cfg; echo_en = echo; conv_cycles = 16'(conv); sck_half = 8'(half);
    model_word = word; start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    if (intrude) begin
      @(negedge clk);
      cfg_word = ~cfg; echo_en = ~echo; start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
    end
    repeat (ec + 2 * n * eh + 6) @(negedge clk);
    check_eq(intrude ? "R8" : "R2", "cnv pulses", rises_cnv - r0, 1);
    check_eq("R2", "cnv width ns", int'(t_fall - t_rise), ec * 20);
    check_eq("R3", "sck falling edges", falls_m, n);
    check_eq("R3", "half period errors", half_err, 0);
    check_eq(intrude ? "R8" : "R4", "din word", din_cap, cfg);
    check_eq("R6", "valid strobes", vcount - v0, (cyc_idx >= 3) ? 1 : 0);
    if (cyc_idx >= 3) begin
      check_eq("R5", "result", last_data, word);
      check_eq("R7", "channel tag", last_chan, hist2[9:7]);
    end
    hist2 = hist1; hist1 = cfg; cyc_idx++;
  endtask

  // {conv[7:0], half[3:0], echo, cfg[13:0], word[13:0]}
  localparam logic [40:0] VECS [0:7] = '{
    {8'd5,  4'd1, 1'b0, 14'h3F80, 14'h0AAA},
    {8'd3,  4'd2, 1'b0, 14'h1281, 14'h3555},
    {8'd8,  4'd1, 1'b1, 14'h0100, 14'h2001},
    {8'd1,  4'd3, 1'b0, 14'h2C3F, 14'h1FFE},
    {8'd0,  4'd0, 1'b1, 14'h0380, 14'h0001},
    {8'd12, 4'd2, 1'b0, 14'h0080, 14'h3FFF},
    {8'd2,  4'd1, 1'b0, 14'h0200, 14'h2000},
    {8'd4,  4'd2, 1'b1, 14'h1555, 14'h0F0F}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1", "cnv", cnv, 0);
    check_eq("R1", "sck", sck, 0);
    check_eq("R1", "din", din, 0);
    check_eq("R1", "res_valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      run_cycle(VECS[i][27:14], VECS[i][13:0], VECS[i][28],
                int'(VECS[i][40:33]), int'(VECS[i][32:29]), 1'b0);
    end

    // R8: requests during a cycle are dropped
    run_cycle(14'h0E80, 14'h2468, 1'b0, 10, 1, 1'b1);
    check_eq("R2", "sck edges while cnv high", sck_in_cnv, 0);

    // R6: reset restarts the start-up skip
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R1", "cnv after re-reset", cnv, 0);
    check_eq("R1", "res_valid after re-reset", res_valid, 0);
    rst_n = 1'b1;
    cyc_idx = 0; hist1 = '0; hist2 = '0;
    run_cycle(14'h0300, 14'h1111, 1'b0, 2, 1, 1'b0);
    run_cycle(14'h0180, 14'h2222, 1'b0, 2, 1, 1'b0);
    run_cycle(14'h0280, 14'h3333, 1'b1, 3, 2, 1'b0);
    run_cycle(14'h0000, 14'h0ABC, 1'b0, 2, 1, 1'b0);
    run_cycle(14'h0380, 14'h3CC3, 1'b0, 1, 2, 1'b0);

    finish_run();
  end

endmodule